// File: doc/BRIEF.md
# Half-Bridge Channel Status Encoder

This block tracks the output status of twelve half-bridge channels. Each channel carries a two-bit state that moves between disabled, enabled, underload and overcurrent. The moves are driven by that channel's enable bit and its qualified fault events, and by two global conditions: a supply fault and a thermal shutdown. The channels form two groups of six. A 16-bit status word shows the group picked by the group-select bit of the last accepted command. It packs a group-wide overcurrent flag, a global supply-fault flag, a group-wide underload flag, the six channel codes and a global thermal-warning flag.

A clear request applies only to the selected group. It brings faulted channels back to their no-fault state and releases a latched thermal shutdown once the temperature condition has gone. The latched thermal-shutdown state is also brought out as its own bit, ready for the serial interface to present ahead of the status word. Fault timing and serial shifting are done elsewhere.

Top module: `hb_status_encoder`

## Requirements
- R1: After reset every channel code is 00, the thermal-shutdown bit is 0, and the status word holds only the live supply-fault and thermal-warning inputs.
- R2: A channel at 00 whose enable is set moves to 11 on the next clock. A channel at 11 whose enable is clear returns to 00.
- R3: A channel at 11 moves to 10 on an underload event and to 01 on an overcurrent event. A channel at 10 moves to 01 on an overcurrent event. When both events arrive in the same cycle, overcurrent wins. Events on a channel at 00 have no effect.
- R4: A channel at 01 never moves to 10. An underload event on a channel at 01 leaves it at 01.
- R5: While the supply-fault input is high, every channel goes to 00 on the next clock. After the input drops, each enabled channel returns to 11 one clock later with no other action.
- R6: The thermal-shutdown input sets a latched shutdown. The latch drives the thermal-shutdown output and holds every channel at 00. Only a clear request taken while the input is low releases it, and enabled channels return to 11 one clock after that.
- R7: A clear request with group select g (0 = channels 0..5, 1 = channels 6..11) moves channels of group g in 01 or 10 to 11 if enabled and to 00 if not. Channels of the other group keep their codes.
- R8: Status word layout: bit 15 is group overcurrent, bit 14 is supply fault, bit 13 is group underload, bits 12:1 hold the six codes of the selected group with its highest channel in bits 12:11 and its lowest in bits 2:1, and bit 0 is thermal warning. The codes are 00 disabled, 01 overcurrent, 10 underload, 11 enabled.
- R9: Bits 15 and 13 are ORs over the selected group only. Bits 14 and 0 follow their global inputs in the same cycle, whatever the group select.
- R10: Clearing the enable of a channel at 01 or 10 leaves its code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 2*GRP_CH (12) | Per-channel enable from the command register |
| oc_evt | input | 2*GRP_CH (12) | Per-channel qualified overcurrent event |
| ul_evt | input | 2*GRP_CH (12) | Per-channel qualified underload event |
| supply_fail | input | 1 | Supply under/overvoltage lockout active |
| therm_sd | input | 1 | Thermal shutdown condition present |
| therm_warn | input | 1 | Thermal warning condition present |
| grp_sel | input | 1 | Group select of the last accepted command |
| clr_req | input | 1 | One-cycle status clear request for the selected group |
| stat_word | output | 2*GRP_CH+4 (16) | Packed status of the selected group |
| tsd_bit | output | 1 | Latched thermal shutdown |

## Verification
The directed pass walks single channels through every edge of the state graph. It covers underload then overcurrent, overcurrent then underload, both in the same cycle, and events on a disabled channel. These separate the priority order from a flat flag register and show the missing path from overcurrent to underload. Clears are sent to the wrong group and then the right one, and to faulted channels with and without their enable, which tells group scoping apart from a global clear. A long pseudo-random pass mixes enables, events, clears and rare supply and thermal faults against a state model kept in the bench. After every clock both groups are read back through the group select, so a stray OR over the wrong group or a misplaced code field shows up.

// File: rtl/hb_status_encoder.sv
`timescale 1ns/1ps
module hb_status_encoder #(
  parameter int GRP_CH = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*GRP_CH-1:0]   ch_en,
  input  logic [2*GRP_CH-1:0]   oc_evt,
  input  logic [2*GRP_CH-1:0]   ul_evt,
  input  logic                  supply_fail,
  input  logic                  therm_sd,
  input  logic                  therm_warn,
  input  logic                  grp_sel,
  input  logic                  clr_req,
  output logic [2*GRP_CH+3:0]   stat_word,
  output logic                  tsd_bit
);
  localparam int NUM_CH = 2 * GRP_CH;
  localparam logic [1:0] ST_OFF = 2'b00;
  localparam logic [1:0] ST_OC  = 2'b01;
  localparam logic [1:0] ST_UL  = 2'b10;
  localparam logic [1:0] ST_ON  = 2'b11;

  logic [NUM_CH-1:0][1:0] st, st_nx;
  logic [NUM_CH-1:0]      clr_mask;
  logic                   tsd_q;
  logic [GRP_CH-1:0][1:0] sel_code;
  logic                   oc_any, ul_any;

  wire force_off = supply_fail | therm_sd | tsd_q;

  assign clr_mask = !clr_req ? '0 :
                    grp_sel  ? {{GRP_CH{1'b1}}, {GRP_CH{1'b0}}}
                             : {{GRP_CH{1'b0}}, {GRP_CH{1'b1}}};

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      st_nx[i] = st[i];
      if (force_off)
        st_nx[i] = ST_OFF;
      else case (st[i])
        ST_OFF: if (ch_en[i]) st_nx[i] = ST_ON;
        ST_ON: begin
          if (!ch_en[i])     st_nx[i] = ST_OFF;
          else if (oc_evt[i]) st_nx[i] = ST_OC;
          else if (ul_evt[i]) st_nx[i] = ST_UL;
        end
        ST_UL: begin
          if (oc_evt[i])        st_nx[i] = ST_OC;
          else if (clr_mask[i]) st_nx[i] = ch_en[i] ? ST_ON : ST_OFF;
        end
        default: if (clr_mask[i]) st_nx[i] = ch_en[i] ? ST_ON : ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= '0;
    else        st <= st_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        tsd_q <= 1'b0;
    else if (therm_sd) tsd_q <= 1'b1;
    else if (clr_req)  tsd_q <= 1'b0;

  always_comb begin
    oc_any = 1'b0;
    ul_any = 1'b0;
    for (int k = 0; k < GRP_CH; k++) begin
      sel_code[k] = grp_sel ? st[k + GRP_CH] : st[k];
      oc_any |= (sel_code[k] == ST_OC);
      ul_any |= (sel_code[k] == ST_UL);
    end
  end

  assign stat_word = {oc_any, supply_fail, ul_any, sel_code, therm_warn};
  assign tsd_bit   = tsd_q;

  genvar g;
  for (g = 0; g < NUM_CH; g++) begin : g_chk
    // R4
    no_oc_to_ul_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st[g] == ST_OC |=> st[g] != ST_UL);
    // R2
    en_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st[g] == ST_OFF && ch_en[g] && !force_off) |=> st[g] == ST_ON);
    // R3
    oc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st[g] == ST_ON && ch_en[g] && oc_evt[g] && !force_off) |=> st[g] == ST_OC);
  end

  // R5
  supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_fail |=> st == '0);
  // R6
  tsd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    therm_sd |=> tsd_bit);
  // R6
  tsd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd_bit && !clr_req) |=> tsd_bit);
endmodule

// File: tb/test_hb_status_encoder.sv
`timescale 1ns/100ps
module test_hb_status_encoder;
  localparam int GRP_CH = 6;
  localparam int NUM_CH = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [NUM_CH-1:0] ch_en = '0, oc_evt = '0, ul_evt = '0;
  logic supply_fail = 0, therm_sd = 0, therm_warn = 0, grp_sel = 0, clr_req = 0;
  logic [15:0] stat_word;
  logic tsd_bit;

  hb_status_encoder #(.GRP_CH(GRP_CH)) i_hb_status_encoder (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .oc_evt(oc_evt), .ul_evt(ul_evt),
    .supply_fail(supply_fail), .therm_sd(therm_sd), .therm_warn(therm_warn),
    .grp_sel(grp_sel), .clr_req(clr_req), .stat_word(stat_word), .tsd_bit(tsd_bit));

  int total = 0, bad = 0;
  bit done = 0;
  logic [1:0] m_st [NUM_CH];
  logic m_tsd;

  function automatic logic [15:0] exp_word(input logic g);
    logic oc = 0, ul = 0;
    logic [11:0] codes;
    for (int k = 0; k < GRP_CH; k++) begin
      logic [1:0] c;
      c = m_st[k + (g ? GRP_CH : 0)];
      codes[2*k +: 2] = c;
      oc |= (c == 2'b01);
      ul |= (c == 2'b10);
    end
    return {oc, supply_fail, ul, codes, therm_warn};
  endfunction

  task automatic check(input string tag);
    logic keep;
    keep = grp_sel;
    for (int g = 0; g < 2; g++) begin
      grp_sel = g[0];
      #0.5;
      total++;
      if (stat_word !== exp_word(g[0])) begin
        bad++;
        $display("FAIL %s group %0d stat_word=%h expected %h", tag, g, stat_word, exp_word(g[0]));
      end
    end
    grp_sel = keep;
    total++;
    if (tsd_bit !== m_tsd) begin
      bad++;
      $display("FAIL %s tsd_bit=%b expected %b", tag, tsd_bit, m_tsd);
    end
  endtask

  task automatic step(input logic [11:0] en, input logic [11:0] oc, input logic [11:0] ul,
                      input logic sf, input logic ts, input logic tw, input logic clr,
                      input logic g, input string tag);
    logic [1:0] nx [NUM_CH];
    logic frc, clr_i, nt;
    ch_en = en; oc_evt = oc; ul_evt = ul; supply_fail = sf; therm_sd = ts;
    therm_warn = tw; clr_req = clr; grp_sel = g;
    frc = sf | ts | m_tsd;
    for (int i = 0; i < NUM_CH; i++) begin
      clr_i = clr && (g == (i >= GRP_CH));
      nx[i] = m_st[i];
      if (frc) nx[i] = 2'b00;
      else if (m_st[i] == 2'b00) begin if (en[i]) nx[i] = 2'b11; end
      else if (m_st[i] == 2'b11) begin
        if (!en[i]) nx[i] = 2'b00;
        else if (oc[i]) nx[i] = 2'b01;
        else if (ul[i]) nx[i] = 2'b10;
      end
      else if (m_st[i] == 2'b10) begin
        if (oc[i]) nx[i] = 2'b01;
        else if (clr_i) nx[i] = en[i] ? 2'b11 : 2'b00;
      end
      else if (clr_i) nx[i] = en[i] ? 2'b11 : 2'b00;
    end
    nt = ts ? 1'b1 : (clr ? 1'b0 : m_tsd);
    @(posedge clk);
    for (int i = 0; i < NUM_CH; i++) m_st[i] = nx[i];
    m_tsd = nt;
    #1;
    check(tag);
  endtask

  localparam logic [11:0] E = 12'h081;

  initial begin
    logic [31:0] lf;
    logic [11:0] ren;
    for (int i = 0; i < NUM_CH; i++) m_st[i] = 2'b00;
    m_tsd = 1'b0;
    #9 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1");
    step(E, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(E, 0, 12'h001, 0, 0, 0, 0, 0, "R3");
    step(E, 12'h001, 0, 0, 0, 0, 0, 0, "R3");
    step(E, 0, 12'h001, 0, 0, 0, 0, 0, "R4");
    step(E, 0, 0, 0, 0, 0, 1, 1, "R7");
    step(E, 0, 0, 0, 0, 0, 1, 0, "R7");
    step(E | 12'h002, 12'h002, 12'h002, 0, 0, 0, 0, 0, "R3");
    step(E | 12'h002, 12'h002, 12'h002, 0, 0, 0, 0, 0, "R3");
    step(E, 12'h080, 12'h080, 0, 0, 0, 0, 0, "R10");
    step(12'h080, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(12'h080, 0, 0, 0, 0, 0, 1, 0, "R7");
    step(E, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(E, 0, 0, 1, 0, 0, 0, 0, "R5");
    step(E, 12'h081, 0, 1, 0, 0, 0, 0, "R5");
    step(E, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(E, 0, 0, 0, 1, 0, 0, 0, "R6");
    step(E, 0, 0, 0, 1, 0, 1, 0, "R6");
    step(E, 0, 0, 0, 0, 0, 0, 0, "R6");
    step(E, 0, 0, 0, 0, 0, 1, 0, "R6");
    step(E, 0, 0, 0, 0, 0, 0, 0, "R6");
    step(E, 0, 0, 1, 0, 1, 0, 1, "R9");
    step(E, 0, 0, 0, 0, 1, 0, 0, "R8");
    lf = 32'h1d872b41;
    ren = 12'hfff;
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5; a = lf;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5; b = lf;
      if (a[31:29] == 3'd0) ren = b[11:0] | b[23:12];
      step(ren, a[11:0] & b[11:0] & b[27:16], a[23:12] & b[23:12],
           (a[28:25] == 4'd0), (b[31:27] == 5'd0), a[24],
           (b[26:24] == 3'd0), b[28], "R3/R7/R9");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog expired, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule